// File: doc/BRIEF.md
# Hardware Lock Elision Controller

This block follows one speculatively elided critical section for a single core. When the core issues a locked read-modify-write that carries the acquire hint, the controller lets the core go ahead without publishing the lock store. It remembers the lock's address, size, prior value and speculative value. From then on it records the cache lines the core reads and writes in two small tag sets. Remote coherence traffic is checked against those sets, and the region ends either in a commit or in an abort.

A commit happens when a release-hinted store writes the original lock value back to the same address with the same size. Everything else that breaks the elision rules aborts the region. The abort reports a 3-bit cause and the program counter of the acquiring instruction. After an abort the next acquire runs as a plain locked access, without elision. A status output tells software whether it is currently inside an elided region.

Top module: `hle_ctrl`

## Requirements
- R1: A request with op code 2 (acquire) arriving while idle and not in fallback raises `elide_o` in the same cycle, and `active_o` is high from the next cycle. The lock's line goes only into the read set, so a remote read snoop of that line does not abort.
- R2: While active, a request with op code 3 (release) at the lock's address and size, whose data equals the value the acquire read (`req_rdata_i`) under the size mask, raises `commit_o` for one cycle in the next cycle and drops `active_o`. Both line sets are then empty.
- R3: A release whose address or size differs from the acquire's aborts with cause 3. A release with matching address and size but a different masked value aborts with cause 2.
- R4: An acquire whose bytes (size code s means 2^s bytes) run past the end of its 64-byte line aborts with cause 7, keeps `elide_o` low and never enters the region. An acquire that ends exactly at the line end is accepted.
- R5: While active, a plain write (op code 1) that overlaps any lock byte aborts with cause 4. An acquire at the lock address aborts with cause 5.
- R6: While active, a read (op code 0) at the lock's address and size raises `fwd_valid_o` in the same cycle, with `fwd_data_o` equal to the acquire's written value. Other reads do not raise it.
- R7: While active, a read snoop (`snp_own_i`=0) that hits a write-set line aborts with cause 0. An ownership snoop (`snp_own_i`=1) that hits a read-set or write-set line also aborts with cause 0. A read snoop of a line that is only in the read set does not abort.
- R8: Each set holds 8 distinct lines. A ninth distinct line aborts with cause 1. Touching a line already in a full set does not abort.
- R9: `irq_i` or `pause_i` high while active aborts with cause 6.
- R10: `abort_o` is a one-cycle pulse in the cycle after the abort, and `restart_pc_o` holds the acquiring `req_pc_i`. Afterwards acquires are not elided (`elide_o` low, `active_o` stays low) until a release is seen outside a region.
- R11: If an abort condition and a committing release occur in the same cycle, the abort wins and `commit_o` stays low. Priority is event, then conflict, then the request-derived causes.
- R12: After reset, `active_o`, `commit_o`, `abort_o` and `elide_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | 0 read, 1 write, 2 acquire-hinted RMW, 3 release-hinted store |
| req_addr_i | input | 64 | Byte address of the access |
| req_size_i | input | 2 | Size code, 2^s bytes |
| req_wdata_i | input | 64 | Value written (for an acquire, the speculative lock value) |
| req_rdata_i | input | 64 | Value the acquire read from memory |
| req_pc_i | input | 64 | Address of the requesting instruction |
| snp_valid_i | input | 1 | Remote snoop valid |
| snp_own_i | input | 1 | 1 ownership request, 0 read |
| snp_line_i | input | 58 | Line address of the snoop |
| irq_i | input | 1 | Interrupt taken |
| pause_i | input | 1 | Spin-wait hint executed |
| elide_o | output | 1 | Current acquire is elided (lock store not published) |
| fwd_valid_o | output | 1 | Current read returns the speculative lock value |
| fwd_data_o | output | 64 | Speculative lock value |
| active_o | output | 1 | Transactional status query |
| commit_o | output | 1 | Region committed (pulse) |
| abort_o | output | 1 | Region aborted (pulse) |
| abort_cause_o | output | 3 | Cause of the last abort |
| restart_pc_o | output | 64 | Restart address after the last abort |

## Verification
A committing release and a remote snoop that hits the write set can land in the same clock edge. The bench provokes this by keeping the snoop inputs asserted during the release request. The commit must then be suppressed and a conflict abort reported instead. This case is judged from `commit_o`, `abort_o` and `abort_cause_o` one cycle later. Directed scenarios also probe both edges of line crossing, a full set that is touched again, and the fallback path after every abort.

// File: rtl/hle_pkg.sv
package hle_pkg;
  localparam int DATA_W = 64;
  localparam int SZ_W   = 2;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_ACQ = 2'd2,
    OP_REL = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    AB_CONFLICT = 3'd0,
    AB_CAPACITY = 3'd1,
    AB_VALUE    = 3'd2,
    AB_SIZEADDR = 3'd3,
    AB_LOCKWR   = 3'd4,
    AB_RECURSE  = 3'd5,
    AB_EVENT    = 3'd6,
    AB_XLINE    = 3'd7
  } cause_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/hle_line_set.sv
module hle_line_set #(
  parameter int TAG_W = 58,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ins_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             ins_hit_o,
  output logic             full_o,
  output logic             look_hit_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] ins_m, look_m;
  logic             wr_en;

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign ins_hit_o  = |ins_m;
  assign look_hit_o = |look_m;
  assign wr_en      = ins_i && !clr_i && !ins_hit_o && !full_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [TAG_W-1:0] tag_q;
    logic             vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        tag_q <= '0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (wr_en && cnt_q == CNT_W'(g)) begin
        vld_q <= 1'b1;
        tag_q <= ins_tag_i;
      end
    end
    assign ins_m[g]  = vld_q && (tag_q == ins_tag_i);
    assign look_m[g] = vld_q && (tag_q == look_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_en) cnt_q <= cnt_q + 1'b1;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r8_full_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (cnt_q == CNT_W'(DEPTH)) || cnt_q == '0);
endmodule

// File: rtl/hle_lock_check.sv
module hle_lock_check
  import hle_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              addr_eq_o,
  output logic              size_eq_o,
  output logic              val_eq_o,
  output logic              overlap_o,
  output logic              xline_o,
  output logic [DATA_W-1:0] lock_val_o
);
  localparam int OFFX_W = OFF_W + 1;
  localparam int EXT_W  = ADDR_W + 1;

  logic [ADDR_W-1:0] lk_addr_q;
  logic [SZ_W-1:0]   lk_size_q;
  logic [DATA_W-1:0] lk_old_q, lk_new_q, lk_mask;
  logic [OFFX_W-1:0] off_end;
  logic [EXT_W-1:0]  r_lo, r_hi, l_lo, l_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_addr_q <= '0;
      lk_size_q <= '0;
      lk_old_q  <= '0;
      lk_new_q  <= '0;
    end else if (load_i) begin
      lk_addr_q <= addr_i;
      lk_size_q <= size_i;
      lk_old_q  <= rdata_i;
      lk_new_q  <= wdata_i;
    end
  end

  assign lk_mask = size_mask(lk_size_q);

  // byte-exact span of the request against the end of its line
  assign off_end = {1'b0, addr_i[OFF_W-1:0]} + (OFFX_W'(1) << size_i);
  assign xline_o = off_end > (OFFX_W'(1) << OFF_W);

  assign r_lo = {1'b0, addr_i};
  assign r_hi = r_lo + (EXT_W'(1) << size_i);
  assign l_lo = {1'b0, lk_addr_q};
  assign l_hi = l_lo + (EXT_W'(1) << lk_size_q);

  assign overlap_o  = (r_lo < l_hi) && (l_lo < r_hi);
  assign addr_eq_o  = (addr_i == lk_addr_q);
  assign size_eq_o  = (size_i == lk_size_q);
  assign val_eq_o   = (wdata_i & lk_mask) == (lk_old_q & lk_mask);
  assign lock_val_o = lk_new_q & lk_mask;

  a_r5_eq_implies_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_eq_o |-> overlap_o);
endmodule

// File: rtl/hle_abort_pick.sv
module hle_abort_pick
  import hle_pkg::*;
(
  input  logic   ev_i,
  input  logic   conf_i,
  input  logic   xline_i,
  input  logic   rec_i,
  input  logic   lwr_i,
  input  logic   sizeaddr_i,
  input  logic   value_i,
  input  logic   cap_i,
  output logic   abort_o,
  output cause_e cause_o
);
  always_comb begin
    abort_o = 1'b1;
    cause_o = AB_CONFLICT;
    if (ev_i)            cause_o = AB_EVENT;
    else if (conf_i)     cause_o = AB_CONFLICT;
    else if (xline_i)    cause_o = AB_XLINE;
    else if (rec_i)      cause_o = AB_RECURSE;
    else if (lwr_i)      cause_o = AB_LOCKWR;
    else if (sizeaddr_i) cause_o = AB_SIZEADDR;
    else if (value_i)    cause_o = AB_VALUE;
    else if (cap_i)      cause_o = AB_CAPACITY;
    else                 abort_o = 1'b0;
  end
endmodule

// File: rtl/hle_ctrl.sv
module hle_ctrl
  import hle_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int SET_DEPTH  = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_valid_i,
  input  logic [1:0]                          req_op_i,
  input  logic [ADDR_W-1:0]                   req_addr_i,
  input  logic [1:0]                          req_size_i,
  input  logic [63:0]                         req_wdata_i,
  input  logic [63:0]                         req_rdata_i,
  input  logic [ADDR_W-1:0]                   req_pc_i,
  input  logic                                snp_valid_i,
  input  logic                                snp_own_i,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snp_line_i,
  input  logic                                irq_i,
  input  logic                                pause_i,
  output logic                                elide_o,
  output logic                                fwd_valid_o,
  output logic [63:0]                         fwd_data_o,
  output logic                                active_o,
  output logic                                commit_o,
  output logic                                abort_o,
  output logic [2:0]                          abort_cause_o,
  output logic [ADDR_W-1:0]                   restart_pc_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  op_e              op;
  logic             is_rd, is_wr, is_acq, is_rel;
  logic [TAG_W-1:0] req_tag;
  logic             active_q, fb_q, commit_q, abort_q;
  cause_e           cause_q, cause_c;
  logic [ADDR_W-1:0] pc_q, rst_pc_q;

  logic addr_eq, size_eq, val_eq, overlap, xline;
  logic rd_hit, rd_full, rd_look, wr_hit, wr_full, wr_look;
  logic start_try, start, ev, conf, rec, lwr, sa, vmis, cap, xl;
  logic rd_need, wr_need, rel_ok, abort_c, commit_c, clr;

  assign op      = op_e'(req_op_i);
  assign is_rd   = req_valid_i && op == OP_RD;
  assign is_wr   = req_valid_i && op == OP_WR;
  assign is_acq  = req_valid_i && op == OP_ACQ;
  assign is_rel  = req_valid_i && op == OP_REL;
  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];

  hle_lock_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lock (
    .clk_i, .rst_ni,
    .load_i    (start),
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .rdata_i   (req_rdata_i),
    .wdata_i   (req_wdata_i),
    .addr_eq_o (addr_eq),
    .size_eq_o (size_eq),
    .val_eq_o  (val_eq),
    .overlap_o (overlap),
    .xline_o   (xline),
    .lock_val_o(fwd_data_o)
  );

  // elided lock store stays out of both sets except the lock line read
  assign start_try = !active_q && !fb_q && is_acq;
  assign start     = start_try && !xline;
  assign xl        = start_try && xline;

  assign ev      = active_q && (irq_i || pause_i);
  assign conf    = active_q && snp_valid_i && (wr_look || (snp_own_i && rd_look));
  assign rec     = active_q && is_acq && addr_eq;
  assign lwr     = active_q && (is_wr || (is_acq && !addr_eq)) && overlap;
  assign rel_ok  = addr_eq && size_eq;
  assign sa      = active_q && is_rel && !rel_ok;
  assign vmis    = active_q && is_rel && rel_ok && !val_eq;
  assign rd_need = active_q && (is_rd || (is_acq && !overlap));
  assign wr_need = active_q && (is_wr || is_acq) && !overlap;
  assign cap     = (rd_need && !rd_hit && rd_full) || (wr_need && !wr_hit && wr_full);

  hle_abort_pick u_pick (
    .ev_i      (ev),
    .conf_i    (conf),
    .xline_i   (xl),
    .rec_i     (rec),
    .lwr_i     (lwr),
    .sizeaddr_i(sa),
    .value_i   (vmis),
    .cap_i     (cap),
    .abort_o   (abort_c),
    .cause_o   (cause_c)
  );

  assign commit_c = active_q && is_rel && rel_ok && val_eq && !abort_c;
  assign clr      = commit_c || abort_c;

  hle_line_set #(.TAG_W(TAG_W), .DEPTH(SET_DEPTH)) u_rd_set (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .ins_i     (start || (rd_need && !abort_c)),
    .ins_tag_i (req_tag),
    .look_tag_i(snp_line_i),
    .ins_hit_o (rd_hit),
    .full_o    (rd_full),
    .look_hit_o(rd_look)
  );

  hle_line_set #(.TAG_W(TAG_W), .DEPTH(SET_DEPTH)) u_wr_set (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .ins_i     (wr_need && !abort_c),
    .ins_tag_i (req_tag),
    .look_tag_i(snp_line_i),
    .ins_hit_o (wr_hit),
    .full_o    (wr_full),
    .look_hit_o(wr_look)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fb_q     <= 1'b0;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      cause_q  <= AB_CONFLICT;
      pc_q     <= '0;
      rst_pc_q <= '0;
    end else begin
      commit_q <= commit_c;
      abort_q  <= abort_c;
      if (start)      active_q <= 1'b1;
      else if (clr)   active_q <= 1'b0;
      if (start)      pc_q <= req_pc_i;
      if (abort_c)                  fb_q <= 1'b1;
      else if (!active_q && is_rel) fb_q <= 1'b0;
      if (abort_c) begin
        cause_q  <= cause_c;
        rst_pc_q <= active_q ? pc_q : req_pc_i;
      end
    end
  end

  assign elide_o       = start;
  assign fwd_valid_o   = active_q && is_rd && addr_eq && size_eq;
  assign active_o      = active_q;
  assign commit_o      = commit_q;
  assign abort_o       = abort_q;
  assign abort_cause_o = cause_q;
  assign restart_pc_o  = rst_pc_q;

  a_r1_enter_after_elide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(elide_o));

  a_r2_commit_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !active_o && $past(active_o));

  a_r11_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o));

  a_r10_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  a_r4_xline_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && abort_cause_o == AB_XLINE) |-> !active_o);

  a_r6_fwd_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> active_o && !elide_o);
endmodule

// File: tb/hle_ctrl_tb.sv
module hle_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0, req_rdata = '0, req_pc = '0;
  logic        snp_valid = 1'b0, snp_own = 1'b0;
  logic [57:0] snp_line = '0;
  logic        irq = 1'b0, pause = 1'b0;
  logic        elide, fwd_valid, active, commit, abort_p;
  logic [63:0] fwd_data, restart_pc;
  logic [2:0]  cause;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic last_elide, last_fwd_v;
  logic [63:0] last_fwd_d;

  localparam logic [63:0] LOCK = 64'h1000;
  localparam logic [63:0] PC0  = 64'h400;

  always #2 clk = ~clk;

  hle_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata), .req_rdata_i(req_rdata),
    .req_pc_i(req_pc), .snp_valid_i(snp_valid), .snp_own_i(snp_own),
    .snp_line_i(snp_line), .irq_i(irq), .pause_i(pause),
    .elide_o(elide), .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data),
    .active_o(active), .commit_o(commit), .abort_o(abort_p),
    .abort_cause_o(cause), .restart_pc_o(restart_pc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_req(input logic [1:0] op, input logic [63:0] addr, input logic [1:0] sz,
                        input logic [63:0] wd, input logic [63:0] rd, input logic [63:0] pc);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_size = sz;
    req_wdata = wd; req_rdata = rd; req_pc = pc;
    #1;
    last_elide = elide; last_fwd_v = fwd_valid; last_fwd_d = fwd_data;
    tick();
    req_valid = 1'b0; snp_valid = 1'b0; snp_own = 1'b0;
  endtask

  task automatic acq(input logic [63:0] addr, input logic [63:0] old_v,
                     input logic [63:0] new_v, input logic [63:0] pc);
    do_req(2'd2, addr, 2'd3, new_v, old_v, pc);
  endtask

  task automatic snoop(input logic [63:0] addr, input logic own);
    snp_valid = 1'b1; snp_own = own; snp_line = addr[63:6];
    tick();
    snp_valid = 1'b0; snp_own = 1'b0;
  endtask

  task automatic expect_abort(input string tag, input logic [2:0] c);
    chk({tag, " abort_o"}, abort_p, 1);
    chk({tag, " cause"}, cause, c);
    chk({tag, " active_o"}, active, 0);
    chk({tag, " commit_o"}, commit, 0);
  endtask

  task automatic fb_clear();
    acq(LOCK, 0, 1, PC0);
    chk("R10 fallback acquire not elided", last_elide, 0);
    chk("R10 fallback stays inactive", active, 0);
    do_req(2'd3, LOCK, 2'd3, 0, 0, PC0);
  endtask

  task automatic t_reset();
    chk("R12 active", active, 0);
    chk("R12 commit", commit, 0);
    chk("R12 abort", abort_p, 0);
    chk("R12 elide", elide, 0);
  endtask

  task automatic t_commit();
    acq(LOCK, 0, 1, PC0);
    chk("R1 elide_o", last_elide, 1);
    chk("R1 active_o", active, 1);
    do_req(2'd1, 64'h2000, 2'd3, 64'h5, 0, 0);
    do_req(2'd0, 64'h3000, 2'd3, 0, 0, 0);
    snoop(LOCK, 1'b0);
    chk("R1 lock line not in write set", abort_p, 0);
    do_req(2'd3, LOCK, 2'd3, 0, 0, 0);
    chk("R2 commit_o", commit, 1);
    chk("R2 active_o low", active, 0);
    chk("R2 no abort", abort_p, 0);
    tick();
    chk("R2 commit pulse ends", commit, 0);
    acq(LOCK, 0, 1, PC0);
    snoop(64'h2000, 1'b1);
    chk("R2 sets emptied", abort_p, 0);
    do_req(2'd3, LOCK, 2'd3, 0, 0, 0);
    chk("R2 second commit", commit, 1);
  endtask

  task automatic t_release_rules();
    acq(LOCK, 0, 1, 64'h480);
    do_req(2'd3, LOCK, 2'd3, 64'h5, 0, 0);
    expect_abort("R3 value mismatch", 3'd2);
    chk("R10 restart_pc", restart_pc, 64'h480);
    tick();
    chk("R10 abort pulse one cycle", abort_p, 0);
    fb_clear();
    acq(LOCK, 0, 1, PC0);
    chk("R10 elision resumes after release", last_elide, 1);
    do_req(2'd3, LOCK, 2'd2, 0, 0, 0);
    expect_abort("R3 size mismatch", 3'd3);
    fb_clear();
    acq(LOCK, 0, 1, PC0);
    do_req(2'd3, LOCK + 64'h8, 2'd3, 0, 0, 0);
    expect_abort("R3 address mismatch", 3'd3);
    fb_clear();
  endtask

  task automatic t_xline();
    acq(64'h103C, 0, 1, 64'h500);
    chk("R4 crossing not elided", last_elide, 0);
    expect_abort("R4 crossing", 3'd7);
    chk("R4 restart_pc", restart_pc, 64'h500);
    fb_clear();
    acq(64'h1038, 0, 1, PC0);
    chk("R4 line-end acquire elided", last_elide, 1);
    do_req(2'd3, 64'h1038, 2'd3, 0, 0, 0);
    chk("R4 line-end commit", commit, 1);
  endtask

  task automatic t_lock_writes();
    acq(LOCK, 0, 1, PC0);
    do_req(2'd1, LOCK + 64'h4, 2'd2, 64'h9, 0, 0);
    expect_abort("R5 lock write", 3'd4);
    fb_clear();
    acq(LOCK, 0, 1, PC0);
    acq(LOCK, 1, 1, PC0);
    expect_abort("R5 recursion", 3'd5);
    fb_clear();
  endtask

  task automatic t_forward();
    acq(LOCK, 64'h77, 64'h99, PC0);
    do_req(2'd0, LOCK, 2'd3, 0, 0, 0);
    chk("R6 fwd_valid", last_fwd_v, 1);
    chk("R6 fwd_data", last_fwd_d, 64'h99);
    do_req(2'd0, LOCK + 64'h8, 2'd3, 0, 0, 0);
    chk("R6 no fwd elsewhere", last_fwd_v, 0);
    do_req(2'd3, LOCK, 2'd3, 64'h77, 0, 0);
    chk("R6 commit after reads", commit, 1);
  endtask

  task automatic t_conflict();
    acq(LOCK, 0, 1, PC0);
    do_req(2'd1, 64'h2000, 2'd3, 0, 0, 0);
    snoop(64'h2010, 1'b0);
    expect_abort("R7 read snoop on write set", 3'd0);
    fb_clear();
    acq(LOCK, 0, 1, PC0);
    do_req(2'd0, 64'h3000, 2'd3, 0, 0, 0);
    snoop(64'h3000, 1'b0);
    chk("R7 read snoop on read set no abort", abort_p, 0);
    chk("R7 still active", active, 1);
    snoop(64'h3020, 1'b1);
    expect_abort("R7 ownership snoop on read set", 3'd0);
    fb_clear();
  endtask

  task automatic t_capacity();
    acq(LOCK, 0, 1, PC0);
    for (int i = 0; i < 8; i++) do_req(2'd1, 64'h10000 + 64'(i) * 64, 2'd3, 0, 0, 0);
    chk("R8 eight lines fit", abort_p, 0);
    chk("R8 still active", active, 1);
    do_req(2'd1, 64'h10008, 2'd3, 0, 0, 0);
    chk("R8 repeat line when full", abort_p, 0);
    do_req(2'd1, 64'h10200, 2'd3, 0, 0, 0);
    expect_abort("R8 ninth line", 3'd1);
    fb_clear();
  endtask

  task automatic t_events();
    acq(LOCK, 0, 1, PC0);
    irq = 1'b1; tick(); irq = 1'b0;
    expect_abort("R9 interrupt", 3'd6);
    fb_clear();
    acq(LOCK, 0, 1, PC0);
    pause = 1'b1; tick(); pause = 1'b0;
    expect_abort("R9 pause", 3'd6);
    fb_clear();
  endtask

  task automatic t_same_cycle();
    acq(LOCK, 0, 1, PC0);
    do_req(2'd1, 64'h2000, 2'd3, 0, 0, 0);
    snp_valid = 1'b1; snp_own = 1'b0; snp_line = 58'h80;
    do_req(2'd3, LOCK, 2'd3, 0, 0, 0);
    expect_abort("R11 conflict beats commit", 3'd0);
    fb_clear();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_commit();
    t_release_rules();
    t_xline();
    t_lock_writes();
    t_forward();
    t_conflict();
    t_capacity();
    t_events();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule